// File: doc/BRIEF.md
# Flash Code-Fetch Line Buffer with Sequential Prefetch

This block sits between a host that fetches code by word address and an engine that reads a serial flash device. It keeps one 64-byte current line so that repeated fetches inside that line complete without touching the flash. In prefetch mode it also keeps a second 64-byte line, filled in the background with the next sequential line. A host read that lands in that second line swaps it into the current role.

A 2-bit policy input selects the behaviour. `00` caches without prefetch. `01` disables caching and turns every host read into one single-word flash read; while `01` is selected, both lines are held invalid. `10` caches and prefetches, which suits long runs of short reads at consecutive addresses. `11` is not a legal setting, because prefetch needs caching: the block behaves as under `00` and raises an error flag.

The flash engine accepts one request at a time. A request is either a full line, returned as 16 words in ascending order, or a single word. A host read that misses while a fill is in flight waits until the fill ends. If that fill is a prefetch of the very line the host wants, the read is then served from the prefetched line and no second request is issued.

Top module: `fetch_linebuf`

## Requirements
- R1: After reset, `host_rdy` and `fl_req` are low, and `pol_err` is low while `pol` is `00`.
- R2: Under policy `00`, a read that misses issues one line request (`fl_line`=1) whose `fl_addr` is the host address with its low 6 bits cleared. The host then receives the 32-bit word at the host address with its low 2 bits cleared.
- R3: Under a caching policy, a read whose line is held valid completes with correct data and issues no flash request.
- R4: Under policy `01`, every host read issues exactly one word request (`fl_line`=0) at the word-aligned host address, even when the address is repeated. The returned word is passed to the host.
- R5: Selecting policy `01` invalidates both lines, so a later read under `00` of a line cached before the switch issues a new line fill.
- R6: Under policy `10`, when a demand fill of line N completes, a line request for line N+1 (address plus 64) follows without any host request.
- R7: Under policy `10`, a read that hits the completed prefetched line gets correct data with no demand request. The prefetch of the line after it is then issued.
- R8: A read of the line that an in-flight prefetch is filling issues no further flash request and completes with correct data once that fill ends.
- R9: `pol_err` is high exactly while `pol` is `11`. Under `11`, and under `00`, no line request is issued except in answer to a pending host read, so no prefetch occurs.
- R10: A hit needs the valid bit and a match of all host address bits above bit 5; a read with the same low 6 bits in another line misses.
- R11: At most one flash request is outstanding: `fl_req` never rises while words of an earlier request are still due.
- R12: `host_rdy` is a one-cycle pulse, raised once per held host read and only while `host_req` was high in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol | input | 2 | Read policy: 00 cache, 01 direct, 10 cache and prefetch, 11 illegal |
| pol_err | output | 1 | High while the illegal policy is selected |
| host_req | input | 1 | Host read request, held until `host_rdy` |
| host_addr | input | AW (24) | Host byte address |
| host_rdy | output | 1 | One-cycle pulse: `host_data` is valid |
| host_data | output | DW (32) | Word returned to the host |
| fl_req | output | 1 | One-cycle flash request pulse |
| fl_line | output | 1 | 1: 64-byte line request, 0: single word |
| fl_addr | output | AW (24) | Flash byte address of the request |
| fl_vld | input | 1 | A returned flash word is present |
| fl_data | input | DW (32) | Returned flash word |

## Verification
The assertions watch on every cycle that only one flash request is outstanding, that line requests are line aligned, and that direct mode never issues a line request. They also check that outside prefetch mode every line request answers a pending host read, and that host responses are single pulses tied to a request. Whether a read hits, misses, swaps in the prefetched line or waits on an in-flight prefetch can only be shown by the bench's scenarios. There, request counts and addresses seen by the flash model are compared with the expected ones, and each returned word is matched against a computed flash image.

// File: rtl/ffb_pkg.sv
package ffb_pkg;

    typedef enum logic [1:0] {
        POL_CACHE  = 2'b00,
        POL_DIRECT = 2'b01,
        POL_PREF   = 2'b10,
        POL_BAD    = 2'b11
    } pol_e;

    localparam int SLOTS = 2;

endpackage

// File: rtl/ffb_line_store.sv
module ffb_line_store #(
    parameter int WORDS = 16,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] widx,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(WORDS)-1:0] ridx,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/ffb_tag_cmp.sv
module ffb_tag_cmp #(
    parameter int TW = 18
) (
    input  logic          valid,
    input  logic [TW-1:0] held_tag,
    input  logic [TW-1:0] req_tag,
    output logic          hit
);
    assign hit = valid && (held_tag == req_tag);
endmodule

// File: rtl/fetch_linebuf.sv
module fetch_linebuf #(
    parameter int AW         = 24,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    pol,
    output logic          pol_err,
    input  logic          host_req,
    input  logic [AW-1:0] host_addr,
    output logic          host_rdy,
    output logic [DW-1:0] host_data,
    output logic          fl_req,
    output logic          fl_line,
    output logic [AW-1:0] fl_addr,
    input  logic          fl_vld,
    input  logic [DW-1:0] fl_data
);
    import ffb_pkg::*;

    localparam int WB   = DW / 8;
    localparam int WPL  = LINE_BYTES / WB;
    localparam int OFFW = $clog2(LINE_BYTES);
    localparam int BW   = $clog2(WB);
    localparam int WIW  = $clog2(WPL);
    localparam int TW   = AW - OFFW;

    typedef struct packed {
        logic [SLOTS-1:0]         vld;
        logic [SLOTS-1:0][TW-1:0] tag;
        logic                     cur;
        logic                     busy;
        logic                     f_line;
        logic                     f_slot;
        logic                     f_pf;
        logic [WIW-1:0]           f_cnt;
        logic [TW-1:0]            f_tag;
        logic                     pf_want;
        logic [TW-1:0]            pf_tag;
        logic                     rdy;
        logic [DW-1:0]            data;
        logic                     freq;
        logic                     fline;
        logic [AW-1:0]            faddr;
    } st_t;

    st_t st_d, st_q;

    logic [TW-1:0]  req_tag;
    logic [WIW-1:0] req_widx;
    logic [SLOTS-1:0] hit;
    logic [DW-1:0]  rd [SLOTS];
    logic           cache_on, pref_on;

    assign req_tag  = host_addr[AW-1:OFFW];
    assign req_widx = host_addr[OFFW-1:BW];
    assign cache_on = (pol_e'(pol) != POL_DIRECT);
    assign pref_on  = (pol_e'(pol) == POL_PREF);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        ffb_line_store #(.WORDS(WPL), .DW(DW)) store_i (
            .clk   (clk),
            .we    (st_q.busy && st_q.f_line && fl_vld && (st_q.f_slot == 1'(s))),
            .widx  (st_q.f_cnt),
            .wdata (fl_data),
            .ridx  (req_widx),
            .rdata (rd[s])
        );
        ffb_tag_cmp #(.TW(TW)) cmp_i (
            .valid    (st_q.vld[s] && cache_on),
            .held_tag (st_q.tag[s]),
            .req_tag  (req_tag),
            .hit      (hit[s])
        );
    end

    always_comb begin
        logic host_act;
        logic alt;
        st_d      = st_q;
        st_d.rdy  = 1'b0;
        st_d.freq = 1'b0;
        host_act  = 1'b0;
        alt       = ~st_q.cur;

        // fill progress
        if (st_q.busy && fl_vld) begin
            if (!st_q.f_line) begin
                st_d.busy = 1'b0;
                st_d.rdy  = 1'b1;
                st_d.data = fl_data;
            end else begin
                st_d.f_cnt = st_q.f_cnt + 1'b1;
                if (st_q.f_cnt == WIW'(WPL - 1)) begin
                    st_d.busy               = 1'b0;
                    st_d.vld[st_q.f_slot]   = cache_on;
                    st_d.tag[st_q.f_slot]   = st_q.f_tag;
                    if (!st_q.f_pf) begin
                        st_d.pf_want = 1'b1;
                        st_d.pf_tag  = st_q.f_tag + 1'b1;
                    end
                end
            end
        end

        // host side
        if (host_req && !st_q.rdy) begin
            if (!cache_on) begin
                if (!st_q.busy) begin
                    host_act    = 1'b1;
                    st_d.freq   = 1'b1;
                    st_d.fline  = 1'b0;
                    st_d.faddr  = {host_addr[AW-1:BW], {BW{1'b0}}};
                    st_d.busy   = 1'b1;
                    st_d.f_line = 1'b0;
                end
            end else if (!(st_q.busy && !st_q.f_line)) begin
                if (hit[st_q.cur]) begin
                    host_act  = 1'b1;
                    st_d.rdy  = 1'b1;
                    st_d.data = rd[st_q.cur];
                end else if (hit[alt]) begin
                    host_act     = 1'b1;
                    st_d.rdy     = 1'b1;
                    st_d.data    = rd[alt];
                    st_d.cur     = alt;
                    st_d.pf_want = 1'b1;
                    st_d.pf_tag  = req_tag + 1'b1;
                end else if (!st_q.busy) begin
                    host_act            = 1'b1;
                    st_d.freq           = 1'b1;
                    st_d.fline          = 1'b1;
                    st_d.faddr          = {req_tag, {OFFW{1'b0}}};
                    st_d.busy           = 1'b1;
                    st_d.f_line         = 1'b1;
                    st_d.f_slot         = st_q.cur;
                    st_d.f_pf           = 1'b0;
                    st_d.f_cnt          = '0;
                    st_d.f_tag          = req_tag;
                    st_d.vld[st_q.cur]  = 1'b0;
                end
            end
        end

        // background next-line fill
        if (!host_act && !st_q.busy && st_q.pf_want && pref_on) begin
            st_d.pf_want = 1'b0;
            if (!(st_q.vld[alt] && st_q.tag[alt] == st_q.pf_tag)) begin
                st_d.freq      = 1'b1;
                st_d.fline     = 1'b1;
                st_d.faddr     = {st_q.pf_tag, {OFFW{1'b0}}};
                st_d.busy      = 1'b1;
                st_d.f_line    = 1'b1;
                st_d.f_slot    = alt;
                st_d.f_pf      = 1'b1;
                st_d.f_cnt     = '0;
                st_d.f_tag     = st_q.pf_tag;
                st_d.vld[alt]  = 1'b0;
            end
        end

        if (!pref_on) st_d.pf_want = 1'b0;
        if (!cache_on) st_d.vld = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pol_err   = (pol_e'(pol) == POL_BAD);
    assign host_rdy  = st_q.rdy;
    assign host_data = st_q.data;
    assign fl_req    = st_q.freq;
    assign fl_line   = st_q.fline;
    assign fl_addr   = st_q.faddr;
endmodule

// File: rtl/fetch_linebuf_chk.sv
module fetch_linebuf_chk #(
    parameter int AW         = 24,
    parameter int DW         = 32,
    parameter int LINE_BYTES = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    pol,
    input logic          host_req,
    input logic          host_rdy,
    input logic          fl_req,
    input logic          fl_line,
    input logic [AW-1:0] fl_addr,
    input logic          fl_vld
);
    localparam int WPL  = LINE_BYTES / (DW / 8);
    localparam int OFFW = $clog2(LINE_BYTES);
    localparam int CW   = $clog2(WPL) + 1;

    logic [CW-1:0] due_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      due_q <= '0;
        else if (fl_req) due_q <= fl_line ? CW'(WPL) : CW'(1);
        else if (fl_vld && due_q != '0) due_q <= due_q - 1'b1;
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> (due_q == '0)); // R11
    AST_VLD_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_vld |-> (due_q != '0)); // R11
    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_line) |-> (fl_addr[OFFW-1:0] == '0)); // R2
    AST_DIRECT_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && $past(pol) == 2'b01) |-> !fl_line); // R4
    AST_NO_PF_OUTSIDE_P10: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_line && $past(pol) != 2'b10) |-> $past(host_req)); // R9
    AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |=> !host_rdy); // R12
    AST_RDY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdy |-> $past(host_req)); // R12
endmodule

bind fetch_linebuf fetch_linebuf_chk #(.AW(AW), .DW(DW), .LINE_BYTES(LINE_BYTES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pol      (pol),
    .host_req (host_req),
    .host_rdy (host_rdy),
    .fl_req   (fl_req),
    .fl_line  (fl_line),
    .fl_addr  (fl_addr),
    .fl_vld   (fl_vld)
);

// File: tb/fetch_linebuf_tb_top.sv
module fetch_linebuf_tb_top;
    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    pol = 2'b00;
    logic          pol_err;
    logic          host_req = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic          host_rdy;
    logic [DW-1:0] host_data;
    logic          fl_req, fl_line;
    logic [AW-1:0] fl_addr;
    logic          fl_vld = 1'b0;
    logic [DW-1:0] fl_data = '0;

    int total = 0;
    int fails = 0;
    int rq_cnt = 0;
    int lat = 3;
    int viol = 0;
    logic [AW-1:0] last_addr = '0;
    logic          last_line = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #4 clk = ~clk;

    fetch_linebuf dut_i (
        .clk(clk), .rst_n(rst_n), .pol(pol), .pol_err(pol_err),
        .host_req(host_req), .host_addr(host_addr), .host_rdy(host_rdy), .host_data(host_data),
        .fl_req(fl_req), .fl_line(fl_line), .fl_addr(fl_addr),
        .fl_vld(fl_vld), .fl_data(fl_data)
    );

    function automatic logic [DW-1:0] fdata(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'hC3A5, a[23:8]} + 32'h0101_0101;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash engine model
    initial begin
        forever begin
            @(negedge clk);
            if (fl_req) begin
                logic [AW-1:0] a;
                int n;
                a = fl_addr;
                rq_cnt++;
                last_addr = fl_addr;
                last_line = fl_line;
                n = fl_line ? 16 : 1;
                repeat (lat) begin
                    @(negedge clk);
                    if (fl_req) viol++;
                end
                for (int i = 0; i < n; i++) begin
                    fl_vld  = 1'b1;
                    fl_data = fdata(a + AW'(4 * i));
                    @(negedge clk);
                    if (fl_req) viol++;
                end
                fl_vld = 1'b0;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && host_rdy) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12 unexpected response", host_data, '0);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(host_data == e, t, host_data, e);
            end
        end
    end

    task automatic host_read(input logic [AW-1:0] a, input string t);
        exp_q.push_back(fdata({a[AW-1:2], 2'b00}));
        tag_q.push_back(t);
        host_addr = a;
        host_req  = 1'b1;
        do @(negedge clk); while (!host_rdy);
        host_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", '0, '0);
        summary();
        $finish;
    end

    initial begin
        int c;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk(!host_rdy, "R1 host_rdy", DW'(host_rdy), '0);
        chk(!fl_req, "R1 fl_req", DW'(fl_req), '0);
        chk(!pol_err, "R1 pol_err", DW'(pol_err), '0);

        // R2 miss fill under policy 00
        host_read(24'h001008, "R2 data");
        chk(rq_cnt == 1, "R2 request count", DW'(rq_cnt), 1);
        chk(last_line && last_addr == 24'h001000, "R2 line address", DW'(last_addr), 32'h1000);

        // R3 hits in the same line
        host_read(24'h001010, "R3 data");
        host_read(24'h00103C, "R3 data");
        chk(rq_cnt == 1, "R3 no flash access", DW'(rq_cnt), 1);

        // R10 same low bits, other line
        host_read(24'h002008, "R10 data");
        chk(rq_cnt == 2 && last_addr == 24'h002000, "R10 miss fills line", DW'(last_addr), 32'h2000);

        // R4 direct mode
        pol = 2'b01;
        idle(1);
        host_read(24'h002009, "R4 data");
        host_read(24'h002009, "R4 data");
        chk(rq_cnt == 4, "R4 one word request per read", DW'(rq_cnt), 4);
        chk(!last_line && last_addr == 24'h002008, "R4 word address", DW'(last_addr), 32'h2008);

        // R5 invalidation by direct mode
        pol = 2'b00;
        idle(1);
        host_read(24'h002008, "R5 data");
        chk(rq_cnt == 5 && last_line, "R5 refill after invalidate", DW'(rq_cnt), 5);

        // R6 prefetch after demand fill
        pol = 2'b10;
        idle(1);
        host_read(24'h004000, "R6 data");
        idle(40);
        chk(rq_cnt == 7, "R6 prefetch issued", DW'(rq_cnt), 7);
        chk(last_line && last_addr == 24'h004040, "R6 prefetch address", DW'(last_addr), 32'h4040);

        // R7 hit in prefetched line
        c = rq_cnt;
        host_read(24'h004044, "R7 data");
        chk(rq_cnt == c, "R7 no demand request", DW'(rq_cnt), DW'(c));
        idle(40);
        chk(rq_cnt == c + 1 && last_addr == 24'h004080, "R7 next prefetch", DW'(last_addr), 32'h4080);

        // R8 read of line still being prefetched
        lat = 30;
        host_read(24'h004084, "R7 data");
        c = rq_cnt;
        host_read(24'h0040C4, "R8 data");
        chk(rq_cnt == c + 1 && last_addr == 24'h0040C0, "R8 no duplicate request", DW'(rq_cnt), DW'(c + 1));
        lat = 3;
        idle(80);

        // R9 illegal policy acts as 00
        pol = 2'b11;
        idle(1);
        chk(pol_err, "R9 error flag set", DW'(pol_err), 1);
        c = rq_cnt;
        host_read(24'h008000, "R9 data");
        idle(40);
        chk(rq_cnt == c + 1, "R9 no prefetch", DW'(rq_cnt), DW'(c + 1));
        host_read(24'h008004, "R3 data");
        chk(rq_cnt == c + 1, "R3 hit under 11", DW'(rq_cnt), DW'(c + 1));
        pol = 2'b10;
        idle(1);
        chk(!pol_err, "R9 error flag clear", DW'(pol_err), 0);

        idle(40);
        chk(viol == 0, "R11 request while busy", DW'(viol), 0);
        chk(exp_q.size() == 0, "R12 missing responses", DW'(exp_q.size()), 0);
        summary();
        $finish;
    end
endmodule